// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while they sit in the decode stage of a five-stage pipeline. Fetch always assumes a branch is not taken and keeps fetching sequentially. Decode presents one instruction descriptor per cycle. For a branch, the block compares the two forwarded register operands with a bitwise XOR and a zero test. It also adds the scaled sign-extended offset to the branch's incremented PC to form the target. When the branch is taken, the block steers the next fetch address to that target and raises a one-cycle flush. The flush zeroes the single wrongly fetched instruction held in the fetch/decode register.

The block keeps a small shadow of the destination registers in the execute and memory stages. A branch cannot yet read a value still being produced by an ALU instruction or a load. When that happens, the block refuses the descriptor and holds the fetch PC until the value can be forwarded. The decode interface is valid/ready. A descriptor is accepted in a cycle where `dec_valid` and `dec_ready` are both high. While `dec_valid` is high and `dec_ready` is low, the sender must hold every descriptor field unchanged. During such a cycle, a bubble enters the execute shadow.

Top module: `branch_resolve_id`

## Requirements
- R1: Reset empties both shadow stages, and anything presented while reset is active is not recorded. A branch presented in the first cycle after reset is never held for a dependency. During reset with `dec_valid` low, `if_flush` is 0, `stall_req` is 0, `pc_sel` is 0 and `next_pc` equals `fe_pc_plus4`.
- R2: `dec_kind` 3 is branch-if-equal. It is taken when the XOR of `dec_opa` and `dec_opb` is all zeros. `br_target` equals `dec_pc_plus4 + (dec_offset << 2)`, modulo 2^XLEN. A taken branch drives `pc_sel` = 1 and `next_pc` = `br_target`.
- R3: `dec_kind` 4 is branch-if-not-equal. It is taken when that XOR is nonzero.
- R4: An accepted branch that is not taken drives `br_taken` = 0, `if_flush` = 0, `pc_sel` = 0 and `next_pc` = `fe_pc_plus4`.
- R5: `if_flush` is high in exactly the cycle in which an accepted branch is taken, and in no other cycle.
- R6: An ALU instruction (`dec_kind` 1) that writes a register the branch reads (`dec_rs` or `dec_rt`) and sits in execute holds the branch for exactly one cycle.
- R7: A load (`dec_kind` 2) that writes a register the branch reads and sits in execute holds the branch for exactly two cycles.
- R8: Such a load sitting in memory, with a gap of one instruction, holds the branch for exactly one cycle.
- R9: An ALU producer already in memory, or any producer two or more instructions ahead, causes no hold, since its value is forwarded.
- R10: While the branch is held, `stall_req` = 1, `dec_ready` = 0, `br_taken` = 0, `if_flush` = 0, `pc_sel` = 2 and `next_pc` = `fe_pc`.
- R11: Register 0 never creates a dependency. A non-branch kind (0 nop, 1 ALU, 2 load) never stalls, even when it reads an in-flight destination.
- R12: With `dec_valid` low, nothing is taken or flushed, nothing stalls, and the descriptor is not recorded as a producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode descriptor valid |
| dec_ready | output | 1 | Descriptor accepted this cycle when high with valid |
| dec_kind | input | 3 | 0 nop, 1 ALU, 2 load, 3 branch-equal, 4 branch-not-equal |
| dec_rd | input | REG_AW | Destination register of ALU/load |
| dec_rs | input | REG_AW | First source register |
| dec_rt | input | REG_AW | Second source register |
| dec_opa | input | XLEN | First operand after decode forwarding |
| dec_opb | input | XLEN | Second operand after decode forwarding |
| dec_offset | input | XLEN | Sign-extended branch offset in words |
| dec_pc_plus4 | input | XLEN | Incremented PC of the decode instruction |
| fe_pc | input | XLEN | PC currently being fetched |
| fe_pc_plus4 | input | XLEN | Incremented fetch PC |
| br_taken | output | 1 | Accepted branch is taken |
| br_target | output | XLEN | Computed branch target |
| pc_sel | output | 2 | 0 sequential, 1 branch target, 2 hold |
| next_pc | output | XLEN | Next fetch address |
| if_flush | output | 1 | Clear the fetch/decode instruction field |
| stall_req | output | 1 | Branch waiting on an in-flight producer |

## Verification
The hardest situation to reach is a load that feeds a branch. In that case the hold must last for exactly two cycles, and the decision must then land with the right target. This only happens when a producer enters the shadow one cycle ahead of the branch and the branch stays presented while bubbles push the producer forward. The bench sweeps producer kind, destination register (including register 0), both source registers, the gap of zero to two nops, the branch kind and operand equality. It counts the hold cycles and compares them with counts worked out from the distance rules.

// File: rtl/brd_pkg.sv
package brd_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ALU  = 3'd1,
    OP_LOAD = 3'd2,
    OP_BEQ  = 3'd3,
    OP_BNE  = 3'd4
  } op_kind_e;

  typedef enum logic [1:0] {
    PCS_SEQ    = 2'd0,
    PCS_BRANCH = 2'd1,
    PCS_HOLD   = 2'd2
  } pc_sel_e;

  function automatic logic kind_is_branch(input logic [2:0] k);
    return (k == 3'(OP_BEQ)) || (k == 3'(OP_BNE));
  endfunction

  function automatic logic kind_writes(input logic [2:0] k);
    return (k == 3'(OP_ALU)) || (k == 3'(OP_LOAD));
  endfunction

endpackage

// File: rtl/brd_zero_cmp.sv
module brd_zero_cmp #(
  parameter int XLEN  = 32,
  parameter int CHUNK = 8
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            equal
);
  localparam int NCH  = (XLEN + CHUNK - 1) / CHUNK;
  localparam int PADW = NCH * CHUNK;

  logic [PADW-1:0] diff;
  logic [NCH-1:0]  part_nz;

  assign diff = PADW'(a ^ b);

  for (genvar i = 0; i < NCH; i++) begin : g_chunk
    assign part_nz[i] = |diff[i*CHUNK +: CHUNK];
  end

  assign equal = ~|part_nz;
endmodule

// File: rtl/brd_target_gen.sv
module brd_target_gen #(
  parameter int XLEN  = 32,
  parameter int SHIFT = 2
) (
  input  logic [XLEN-1:0] pc_plus4,
  input  logic [XLEN-1:0] offset,
  output logic [XLEN-1:0] target
);
  logic [XLEN-1:0] scaled;

  assign scaled = offset << SHIFT;
  assign target = pc_plus4 + scaled;
endmodule

// File: rtl/brd_scoreboard.sv
module brd_scoreboard #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_wr,
  input  logic              push_ld,
  input  logic [REG_AW-1:0] push_rd,
  input  logic [REG_AW-1:0] src_a,
  input  logic [REG_AW-1:0] src_b,
  output logic              hit_ex,
  output logic              hit_mem_load
);
  localparam int DEPTH = 2;

  logic              st_wr [DEPTH];
  logic              st_ld [DEPTH];
  logic [REG_AW-1:0] st_rd [DEPTH];
  logic              hit   [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic              nxt_wr;
    logic              nxt_ld;
    logic [REG_AW-1:0] nxt_rd;

    if (s == 0) begin : g_head
      assign nxt_wr = push_wr;
      assign nxt_ld = push_ld;
      assign nxt_rd = push_rd;
    end else begin : g_tail
      assign nxt_wr = st_wr[s-1];
      assign nxt_ld = st_ld[s-1];
      assign nxt_rd = st_rd[s-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_wr[s] <= 1'b0;
        st_ld[s] <= 1'b0;
        st_rd[s] <= '0;
      end else begin
        st_wr[s] <= nxt_wr;
        st_ld[s] <= nxt_ld;
        st_rd[s] <= nxt_rd;
      end
    end

    assign hit[s] = st_wr[s] && (st_rd[s] != '0) &&
                    ((st_rd[s] == src_a) || (st_rd[s] == src_b));
  end

  assign hit_ex       = hit[0];
  assign hit_mem_load = hit[1] && st_ld[1];
endmodule

// File: rtl/branch_resolve_id.sv
module branch_resolve_id
  import brd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  output logic              dec_ready,
  input  logic [2:0]        dec_kind,
  input  logic [REG_AW-1:0] dec_rd,
  input  logic [REG_AW-1:0] dec_rs,
  input  logic [REG_AW-1:0] dec_rt,
  input  logic [XLEN-1:0]   dec_opa,
  input  logic [XLEN-1:0]   dec_opb,
  input  logic [XLEN-1:0]   dec_offset,
  input  logic [XLEN-1:0]   dec_pc_plus4,
  input  logic [XLEN-1:0]   fe_pc,
  input  logic [XLEN-1:0]   fe_pc_plus4,
  output logic              br_taken,
  output logic [XLEN-1:0]   br_target,
  output logic [1:0]        pc_sel,
  output logic [XLEN-1:0]   next_pc,
  output logic              if_flush,
  output logic              stall_req
);
  logic is_branch;
  logic ops_equal;
  logic cond_met;
  logic hit_ex;
  logic hit_mem_load;
  logic accept;
  logic push_wr;
  logic push_ld;

  brd_zero_cmp #(.XLEN(XLEN)) u_cmp (
    .a     (dec_opa),
    .b     (dec_opb),
    .equal (ops_equal)
  );

  brd_target_gen #(.XLEN(XLEN), .SHIFT(2)) u_tgt (
    .pc_plus4 (dec_pc_plus4),
    .offset   (dec_offset),
    .target   (br_target)
  );

  brd_scoreboard #(.REG_AW(REG_AW)) u_sb (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_wr      (push_wr),
    .push_ld      (push_ld),
    .push_rd      (dec_rd),
    .src_a        (dec_rs),
    .src_b        (dec_rt),
    .hit_ex       (hit_ex),
    .hit_mem_load (hit_mem_load)
  );

  assign is_branch = dec_valid && kind_is_branch(dec_kind);
  assign stall_req = is_branch && (hit_ex || hit_mem_load);
  assign dec_ready = !stall_req;
  assign accept    = dec_valid && !stall_req;

  assign push_wr = accept && kind_writes(dec_kind);
  assign push_ld = accept && (dec_kind == 3'(OP_LOAD));

  always_comb begin
    cond_met = 1'b0;
    if (dec_kind == 3'(OP_BEQ)) cond_met = ops_equal;
    else if (dec_kind == 3'(OP_BNE)) cond_met = !ops_equal;
  end

  assign br_taken = is_branch && !stall_req && cond_met;
  assign if_flush = br_taken;

  always_comb begin
    if (stall_req) begin
      pc_sel  = 2'(PCS_HOLD);
      next_pc = fe_pc;
    end else if (br_taken) begin
      pc_sel  = 2'(PCS_BRANCH);
      next_pc = br_target;
    end else begin
      pc_sel  = 2'(PCS_SEQ);
      next_pc = fe_pc_plus4;
    end
  end
endmodule

// File: rtl/brd_checker.sv
module brd_checker #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dec_valid,
  input logic              dec_ready,
  input logic [2:0]        dec_kind,
  input logic [REG_AW-1:0] dec_rs,
  input logic [REG_AW-1:0] dec_rt,
  input logic [XLEN-1:0]   fe_pc,
  input logic [XLEN-1:0]   fe_pc_plus4,
  input logic              br_taken,
  input logic [XLEN-1:0]   br_target,
  input logic [1:0]        pc_sel,
  input logic [XLEN-1:0]   next_pc,
  input logic              if_flush,
  input logic              stall_req
);
  AST_HOLD_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> (!if_flush && !br_taken && pc_sel == 2'd2 && next_pc == fe_pc)); // R10

  AST_HOLD_KEEPS_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_kind) && $stable(dec_rs) && $stable(dec_rt))); // R10

  AST_STALL_AT_MOST_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req && $past(stall_req)) |=> !stall_req); // R7

  AST_TAKEN_TO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (pc_sel == 2'd1 && next_pc == br_target)); // R2

  AST_FLUSH_WITH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |-> (br_taken && !stall_req)); // R5

  AST_NONBRANCH_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid || dec_kind < 3'd3) |-> (!stall_req && !if_flush)); // R11

  AST_SEQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_taken && !stall_req) |-> (next_pc == fe_pc_plus4)); // R4
endmodule

bind branch_resolve_id brd_checker #(.XLEN(XLEN), .REG_AW(REG_AW)) u_brd_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dec_valid   (dec_valid),
  .dec_ready   (dec_ready),
  .dec_kind    (dec_kind),
  .dec_rs      (dec_rs),
  .dec_rt      (dec_rt),
  .fe_pc       (fe_pc),
  .fe_pc_plus4 (fe_pc_plus4),
  .br_taken    (br_taken),
  .br_target   (br_target),
  .pc_sel      (pc_sel),
  .next_pc     (next_pc),
  .if_flush    (if_flush),
  .stall_req   (stall_req)
);

// File: tb/test_branch_resolve_id.sv
module test_branch_resolve_id;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int RAW  = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic dec_valid;
  logic dec_ready;
  logic [2:0] dec_kind;
  logic [RAW-1:0] dec_rd, dec_rs, dec_rt;
  logic [XLEN-1:0] dec_opa, dec_opb, dec_offset, dec_pc_plus4, fe_pc, fe_pc_plus4;
  logic br_taken;
  logic [XLEN-1:0] br_target;
  logic [1:0] pc_sel;
  logic [XLEN-1:0] next_pc;
  logic if_flush;
  logic stall_req;

  int nchecks = 0;
  int nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolve_id #(.XLEN(XLEN), .REG_AW(RAW)) i_branch_resolve_id (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_kind(dec_kind), .dec_rd(dec_rd), .dec_rs(dec_rs), .dec_rt(dec_rt),
    .dec_opa(dec_opa), .dec_opb(dec_opb), .dec_offset(dec_offset),
    .dec_pc_plus4(dec_pc_plus4), .fe_pc(fe_pc), .fe_pc_plus4(fe_pc_plus4),
    .br_taken(br_taken), .br_target(br_target), .pc_sel(pc_sel),
    .next_pc(next_pc), .if_flush(if_flush), .stall_req(stall_req)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] k, input logic [RAW-1:0] rd,
                       input logic [RAW-1:0] rs, input logic [RAW-1:0] rt,
                       input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                       input logic [XLEN-1:0] off, input logic [XLEN-1:0] pc4);
    dec_valid = v; dec_kind = k; dec_rd = rd; dec_rs = rs; dec_rt = rt;
    dec_opa = a; dec_opb = b; dec_offset = off; dec_pc_plus4 = pc4;
  endtask

  task automatic nop();
    drive(1'b1, 3'd0, '0, '0, '0, '0, '0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    int idx;
    rst_n = 1'b0;
    fe_pc = 32'h0000_2000; fe_pc_plus4 = 32'h0000_2004;
    drive(1'b0, 3'd3, 5'd0, 5'd0, 5'd0, '0, '0, '0, '0);
    @(negedge clk);
    #1;
    chk(!if_flush && !stall_req && pc_sel == 2'd0 && next_pc == fe_pc_plus4, "R1 reset idle", next_pc, fe_pc_plus4);
    // R1: producer presented during reset must not be recorded
    @(negedge clk);
    drive(1'b1, 3'd2, 5'd1, 5'd0, 5'd0, '0, '0, '0, '0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 3'd3, 5'd0, 5'd1, 5'd2, 32'h55, 32'h55, 32'd3, 32'h100);
    #1;
    chk(!stall_req, "R1 no hold after reset", 32'(stall_req), 0);
    chk(br_taken && if_flush && next_pc == 32'h10c, "R2 first branch", next_pc, 32'h10c);
    @(negedge clk);

    // R12: invalid producer not recorded, invalid branch does nothing
    drive(1'b0, 3'd1, 5'd6, 5'd0, 5'd0, '0, '0, '0, '0);
    #1;
    chk(!stall_req && !if_flush, "R12 invalid alu", 32'(stall_req), 0);
    @(negedge clk);
    drive(1'b0, 3'd3, 5'd0, 5'd6, 5'd6, 32'h7, 32'h7, 32'd1, 32'h200);
    #1;
    chk(!br_taken && !if_flush && pc_sel == 2'd0 && next_pc == fe_pc_plus4, "R12 invalid branch", 32'(pc_sel), 0);
    @(negedge clk);
    drive(1'b1, 3'd4, 5'd0, 5'd6, 5'd6, 32'h7, 32'h8, 32'd1, 32'h200);
    #1;
    chk(!stall_req && br_taken, "R12 no recorded producer", 32'(stall_req), 0);
    @(negedge clk);

    // R11: non-branch reading an in-flight load destination never stalls
    drive(1'b1, 3'd2, 5'd7, 5'd0, 5'd0, '0, '0, '0, '0);
    @(negedge clk);
    drive(1'b1, 3'd1, 5'd8, 5'd7, 5'd7, '0, '0, '0, '0);
    #1;
    chk(!stall_req && dec_ready, "R11 alu consumer", 32'(stall_req), 0);
    @(negedge clk);

    idx = 0;
    for (int pk = 0; pk < 3; pk++)
      for (int prd = 0; prd < 4; prd++)
        for (int rs = 1; rs < 4; rs++)
          for (int rt = 1; rt < 4; rt++)
            for (int g = 0; g < 3; g++)
              for (int bk = 3; bk < 5; bk++)
                for (int eq = 0; eq < 2; eq++) begin
                  logic [2:0] pkind;
                  bit dep;
                  int exp_st;
                  int st;
                  bit exp_tk;
                  logic [XLEN-1:0] a, b, off, pc4, tgt, exp_pc;
                  string rq;
                  idx++;
                  pkind = (pk == 0) ? 3'd1 : (pk == 1) ? 3'd2 : 3'd0;
                  dep = (pkind != 3'd0) && (prd != 0) && (prd == rs || prd == rt);
                  if (!dep) exp_st = 0;
                  else if (pkind == 3'd1) exp_st = (g == 0) ? 1 : 0;
                  else exp_st = (g == 0) ? 2 : (g == 1) ? 1 : 0;
                  if (!dep) rq = (prd == 0 && pkind != 3'd0) ? "R11" : "R9";
                  else if (pkind == 3'd1) rq = (g == 0) ? "R6" : "R9";
                  else rq = (g == 0) ? "R7" : (g == 1) ? "R8" : "R9";
                  a = 32'h1234_5000 ^ (idx * 32'h9e37);
                  b = eq ? a : (a ^ (32'h1 << (idx % XLEN)));
                  off = 32'(idx * 53 - 30000);
                  pc4 = 32'h0001_0000 + 32'(idx * 4);
                  tgt = pc4 + off * 4;
                  exp_tk = (bk == 3) ? (eq == 1) : (eq == 0);
                  fe_pc = pc4 + 32'd4; fe_pc_plus4 = pc4 + 32'd8;
                  exp_pc = exp_tk ? tgt : fe_pc_plus4;

                  nop(); @(negedge clk);
                  nop(); @(negedge clk);
                  drive(1'b1, pkind, RAW'(prd), 5'd9, 5'd10, '0, '0, '0, '0);
                  @(negedge clk);
                  for (int gi = 0; gi < g; gi++) begin nop(); @(negedge clk); end
                  drive(1'b1, 3'(bk), 5'd0, RAW'(rs), RAW'(rt), a, b, off, pc4);
                  st = 0;
                  for (int n = 0; n < 5; n++) begin
                    #1;
                    if (!stall_req) break;
                    st++;
                    chk(!if_flush && !br_taken && !dec_ready, "R10 no action while held", 32'(if_flush), 0);
                    chk(pc_sel == 2'd2 && next_pc == fe_pc, "R10 hold pc", next_pc, fe_pc);
                    @(negedge clk);
                  end
                  chk(st == exp_st, rq, st, exp_st);
                  chk(br_target == tgt, "R2 target", br_target, tgt);
                  chk(br_taken == exp_tk, (bk == 3) ? "R2 equal decision" : "R3 not-equal decision", 32'(br_taken), 32'(exp_tk));
                  chk(if_flush == exp_tk, "R5 flush", 32'(if_flush), 32'(exp_tk));
                  chk(next_pc == exp_pc && pc_sel == (exp_tk ? 2'd1 : 2'd0), exp_tk ? "R2 next pc" : "R4 next pc", next_pc, exp_pc);
                  @(negedge clk);
                  nop();
                  #1;
                  chk(!if_flush, "R5 single pulse", 32'(if_flush), 0);
                end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule